// File: doc/BRIEF.md
# Two-Level Frame/Element Transfer Address Generator

This block steps a DMA-style transfer between a peripheral-side memory, organised as fixed-size 16-byte instruction slots, and a linear buffer in system memory. It holds two nested down-counters. An element counter runs inside a frame counter. For every element the block issues one read request and then one write request. When the write is acknowledged, it computes the next peripheral-side and buffer-side addresses.

The peripheral-side address can step through consecutive instruction slots. When it does, it returns to its programmed start at the beginning of every frame. The buffer-side address either post-increments by the transfer size or stays fixed, and it never reloads between frames. A 64-bit element moves a control word at the slot base and a data word at base + 4. The block therefore presents both word addresses on each side. A direction bit swaps which side is read and which is written. It does not alter either address sequence.

A one-cycle start pulse loads the configuration. The block raises busy, runs frame × element request pairs, and then pulses done.

Top module: `xfer_addr_gen`

## Requirements
- R1: One cycle after a start pulse accepted while idle with non-zero counts, busy is 1 and rd_req_o is 1. At that point the first addresses equal the programmed start addresses.
- R2: Each element raises rd_req_o and holds it until rd_ack_i, then raises wr_req_o in the next cycle and holds it until wr_ack_i. The two requests are never high together. An acknowledge on the side that has no request pending is ignored.
- R3: A job issues exactly frame_cnt × elem_cnt request pairs. The elements of each frame are counted from elem_cnt down to 1, and the frames from frame_cnt down to 1.
- R4: With cfg_periph_step_i=1 the peripheral-side address rises by 16 (0x10) after each element and returns to its start at the first element of each frame. With cfg_periph_step_i=0 it stays at its start address.
- R5: With cfg_buf_step_i=1 the buffer-side address rises after every element by 8 when cfg_wide_i=1, or by 4 when cfg_wide_i=0. It continues across frame boundaries without reloading.
- R6: With cfg_buf_step_i=0 the buffer-side address stays at its start address for the whole job.
- R7: With cfg_wide_i=1, xfer_wide_o is 1 and the second-word address on each side equals that side's base address + 4. With cfg_wide_i=0, xfer_wide_o is 0.
- R8: With cfg_dir_i=0 the read address comes from the peripheral side and the write address from the buffer side. With cfg_dir_i=1 the two roles are swapped.
- R9: done_o is high for exactly one cycle, the cycle after the final wr_ack_i. busy_o is 0 in that cycle and remains 0 afterwards.
- R10: A start pulse while busy is ignored. The running job keeps its addresses and its element count.
- R11: A start with cfg_elem_cnt_i=0 or cfg_frame_cnt_i=0 gives done_o in the next cycle, issues no request, and leaves busy at 0.
- R12: After reset busy_o, done_o, rd_req_o and wr_req_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, loads the configuration |
| cfg_periph_base_i | input | ADDR_W | Peripheral-side start address (control word of first slot) |
| cfg_buf_base_i | input | ADDR_W | Buffer-side start address |
| cfg_elem_cnt_i | input | CNT_W | Elements per frame |
| cfg_frame_cnt_i | input | CNT_W | Number of frames |
| cfg_dir_i | input | 1 | 0: read peripheral, write buffer; 1: read buffer, write peripheral |
| cfg_wide_i | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| cfg_periph_step_i | input | 1 | 1: peripheral address steps by slot stride |
| cfg_buf_step_i | input | 1 | 1: buffer address post-increments |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read base address |
| rd_addr2_o | output | ADDR_W | Read second-word address |
| rd_ack_i | input | 1 | Read acknowledge |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | ADDR_W | Write base address |
| wr_addr2_o | output | ADDR_W | Write second-word address |
| wr_ack_i | input | 1 | Write acknowledge |
| xfer_wide_o | output | 1 | Current job moves two words per element |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the frame boundary first. If the peripheral side fails to reload there, the address drifts to 0x64 and beyond on the second frame. If the buffer side reloads there by mistake, it falls back to its start address.

The bench also covers the following cases:
- **Acknowledge latency and stray acknowledges.** A design that advances on the wrong side's acknowledge would skip its write phase.
- **A start pulse in mid-job.** A design that accepts it would jump to the new addresses.
- **Zero counts.** A design without the zero check would underflow and issue a long run of requests.
- **Done-pulse timing.** The bench checks the exact cycle of done, and an off-by-one count shows up as an extra or a missing element.

// File: rtl/xag_pkg.sv
package xag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } xag_state_e;
endpackage

// File: rtl/xag_counters.sv
module xag_counters #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] elem_cnt_i,
  input  logic [CNT_W-1:0] frame_cnt_i,
  output logic             zero_o,
  output logic             frame_end_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] elem_q, elem_d;
  logic [CNT_W-1:0] frame_q, frame_d;
  logic [CNT_W-1:0] reload_q, reload_d;

  assign zero_o      = (elem_cnt_i == '0) || (frame_cnt_i == '0);
  assign frame_end_o = (elem_q == ONE);
  assign last_o      = frame_end_o && (frame_q == ONE);

  always_comb begin
    elem_d   = elem_q;
    frame_d  = frame_q;
    reload_d = reload_q;
    if (load_i) begin
      elem_d   = elem_cnt_i;
      frame_d  = frame_cnt_i;
      reload_d = elem_cnt_i;
    end else if (step_i) begin
      if (frame_end_o) begin
        elem_d  = reload_q;
        frame_d = frame_q - ONE;
      end else begin
        elem_d = elem_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q   <= '0;
      frame_q  <= '0;
      reload_q <= '0;
    end else if (load_i || step_i) begin
      elem_q   <= elem_d;
      frame_q  <= frame_d;
      reload_q <= reload_d;
    end
  end
endmodule

// File: rtl/xag_addr.sv
module xag_addr #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              frame_end_i,
  input  logic [ADDR_W-1:0] periph_base_i,
  input  logic [ADDR_W-1:0] buf_base_i,
  input  logic              periph_step_i,
  input  logic              buf_step_i,
  input  logic              wide_i,
  output logic [ADDR_W-1:0] periph_addr_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              wide_o
);
  localparam logic [ADDR_W-1:0] SLOT_INC = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] INC_W64  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] INC_W32  = ADDR_W'(4);

  logic [ADDR_W-1:0] p_q, p_d, pbase_q, pbase_d, b_q, b_d;
  logic              pstep_q, pstep_d, bstep_q, bstep_d, wide_q, wide_d;
  logic [ADDR_W-1:0] b_inc;

  assign b_inc = wide_q ? INC_W64 : INC_W32;

  always_comb begin
    p_d     = p_q;
    pbase_d = pbase_q;
    b_d     = b_q;
    pstep_d = pstep_q;
    bstep_d = bstep_q;
    wide_d  = wide_q;
    if (load_i) begin
      p_d     = periph_base_i;
      pbase_d = periph_base_i;
      b_d     = buf_base_i;
      pstep_d = periph_step_i;
      bstep_d = buf_step_i;
      wide_d  = wide_i;
    end else if (step_i) begin
      if (frame_end_i)  p_d = pbase_q;
      else if (pstep_q) p_d = p_q + SLOT_INC;
      if (bstep_q)      b_d = b_q + b_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q     <= '0;
      pbase_q <= '0;
      b_q     <= '0;
      pstep_q <= 1'b0;
      bstep_q <= 1'b0;
      wide_q  <= 1'b0;
    end else if (load_i || step_i) begin
      p_q     <= p_d;
      pbase_q <= pbase_d;
      b_q     <= b_d;
      pstep_q <= pstep_d;
      bstep_q <= bstep_d;
      wide_q  <= wide_d;
    end
  end

  assign periph_addr_o = p_q;
  assign buf_addr_o    = b_q;
  assign wide_o        = wide_q;
endmodule

// File: rtl/xag_fsm.sv
module xag_fsm
  import xag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic zero_i,
  input  logic last_i,
  input  logic rd_ack_i,
  input  logic wr_ack_i,
  output logic load_o,
  output logic step_o,
  output logic rd_req_o,
  output logic wr_req_o,
  output logic busy_o,
  output logic done_o
);
  xag_state_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    step_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        st_d   = zero_i ? ST_FIN : ST_RD;
      end
      ST_RD: if (rd_ack_i) st_d = ST_WR;
      ST_WR: if (wr_ack_i) begin
        step_o = 1'b1;
        st_d   = last_i ? ST_FIN : ST_RD;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign rd_req_o = (st_q == ST_RD);
  assign wr_req_o = (st_q == ST_WR);
  assign busy_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign done_o   = (st_q == ST_FIN);
endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] cfg_periph_base_i,
  input  logic [ADDR_W-1:0] cfg_buf_base_i,
  input  logic [CNT_W-1:0]  cfg_elem_cnt_i,
  input  logic [CNT_W-1:0]  cfg_frame_cnt_i,
  input  logic              cfg_dir_i,
  input  logic              cfg_wide_i,
  input  logic              cfg_periph_step_i,
  input  logic              cfg_buf_step_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] rd_addr2_o,
  input  logic              rd_ack_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] wr_addr2_o,
  input  logic              wr_ack_i,
  output logic              xfer_wide_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] WORD2_OFS = ADDR_W'(4);

  logic              load, step, zero, frame_end, last;
  logic [ADDR_W-1:0] periph_addr, buf_addr;
  logic              dir_q, dir_d;

  xag_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .zero_i   (zero),
    .last_i   (last),
    .rd_ack_i (rd_ack_i),
    .wr_ack_i (wr_ack_i),
    .load_o   (load),
    .step_o   (step),
    .rd_req_o (rd_req_o),
    .wr_req_o (wr_req_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  xag_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .step_i      (step),
    .elem_cnt_i  (cfg_elem_cnt_i),
    .frame_cnt_i (cfg_frame_cnt_i),
    .zero_o      (zero),
    .frame_end_o (frame_end),
    .last_o      (last)
  );

  xag_addr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_addr (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load),
    .step_i        (step),
    .frame_end_i   (frame_end),
    .periph_base_i (cfg_periph_base_i),
    .buf_base_i    (cfg_buf_base_i),
    .periph_step_i (cfg_periph_step_i),
    .buf_step_i    (cfg_buf_step_i),
    .wide_i        (cfg_wide_i),
    .periph_addr_o (periph_addr),
    .buf_addr_o    (buf_addr),
    .wide_o        (xfer_wide_o)
  );

  always_comb dir_d = load ? cfg_dir_i : dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dir_q <= 1'b0;
    else if (load) dir_q <= dir_d;
  end

  assign rd_addr_o  = dir_q ? buf_addr : periph_addr;
  assign wr_addr_o  = dir_q ? periph_addr : buf_addr;
  assign rd_addr2_o = rd_addr_o + WORD2_OFS;
  assign wr_addr2_o = wr_addr_o + WORD2_OFS;
endmodule

// File: rtl/xfer_addr_gen_chk.sv
module xfer_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_req_o,
  input logic              rd_ack_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              wr_req_o,
  input logic              wr_ack_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              busy_o,
  input logic              done_o
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o)); // R2
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && rd_ack_i |=> wr_req_o); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R9
  AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o || wr_req_o) |-> busy_o); // R12
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && !done_o |=> busy_o || done_o); // R1
endmodule

bind xfer_addr_gen xfer_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rd_req_o  (rd_req_o),
  .rd_ack_i  (rd_ack_i),
  .rd_addr_o (rd_addr_o),
  .wr_req_o  (wr_req_o),
  .wr_ack_i  (wr_ack_i),
  .wr_addr_o (wr_addr_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/xfer_addr_gen_tb.sv
module xfer_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pbase = '0, bbase = '0;
  logic [7:0]  ecnt = '0, fcnt = '0;
  logic        dir = 1'b0, wide = 1'b0, pstep = 1'b0, bstep = 1'b0;
  logic        rd_req, wr_req, rd_ack = 1'b0, wr_ack = 1'b0;
  logic [31:0] rd_addr, rd_addr2, wr_addr, wr_addr2;
  logic        xwide, busy, done;
  int          compared = 0, mismatched = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  xfer_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .cfg_periph_base_i(pbase), .cfg_buf_base_i(bbase),
    .cfg_elem_cnt_i(ecnt), .cfg_frame_cnt_i(fcnt),
    .cfg_dir_i(dir), .cfg_wide_i(wide),
    .cfg_periph_step_i(pstep), .cfg_buf_step_i(bstep),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_addr2_o(rd_addr2), .rd_ack_i(rd_ack),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_addr2_o(wr_addr2), .wr_ack_i(wr_ack),
    .xfer_wide_o(xwide), .busy_o(busy), .done_o(done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: expected address lists built from the requirements.
  task automatic run_job(input logic [31:0] pb, input logic [31:0] bb,
                         input int ec, input int fc, input bit d, input bit w,
                         input bit ps, input bit bs, input int rlat, input int wlat,
                         input bit stray, input bit mid_start);
    logic [31:0] exp_rd[$];
    logic [31:0] exp_wr[$];
    int          inc = w ? 8 : 4;
    for (int f = 0; f < fc; f++)
      for (int e = 0; e < ec; e++) begin
        logic [31:0] pa, ba;
        pa = pb + (ps ? 32'(16 * e) : 32'd0);          // R4
        ba = bb + (bs ? 32'(inc * (f * ec + e)) : 32'd0); // R5 R6
        exp_rd.push_back(d ? ba : pa);                 // R8
        exp_wr.push_back(d ? pa : ba);
      end
    pbase = pb; bbase = bb; ecnt = 8'(ec); fcnt = 8'(fc);
    dir = d; wide = w; pstep = ps; bstep = bs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (exp_rd.size() == 0) begin
      chk("R11 done after zero count", 32'(done), 32'd1);
      chk("R11 no request", 32'(rd_req | wr_req), 32'd0);
      chk("R11 not busy", 32'(busy), 32'd0);
      @(negedge clk);
      chk("R11 done single", 32'(done), 32'd0);
      return;
    end
    chk("R1 busy after start", 32'(busy), 32'd1);
    chk("R7 wide flag", 32'(xwide), 32'(w));
    for (int k = 0; k < exp_rd.size(); k++) begin
      for (int c = 0; c <= rlat; c++) begin
        chk("R2 rd_req held", 32'(rd_req), 32'd1);
        chk("R2 wr_req low in read", 32'(wr_req), 32'd0);
        chk(k == 0 ? "R1 first rd addr" : "R3 rd addr", rd_addr, exp_rd[k]);
        if (w) chk("R7 rd second word", rd_addr2, exp_rd[k] + 32'd4);
        rd_ack = (c == rlat);
        wr_ack = stray && (c < rlat);
        if (mid_start && k == 1 && c == 0) begin
          start = 1'b1; pbase = 32'h900; bbase = 32'h400; ecnt = 8'd1; fcnt = 8'd1; dir = ~d;
        end
        @(negedge clk);
        start = 1'b0;
      end
      rd_ack = 1'b0; wr_ack = 1'b0;
      for (int c = 0; c <= wlat; c++) begin
        chk("R2 wr_req held", 32'(wr_req), 32'd1);
        chk("R2 rd_req low in write", 32'(rd_req), 32'd0);
        chk(mid_start ? "R10 wr addr" : "R5 wr addr", wr_addr, exp_wr[k]);
        if (w) chk("R7 wr second word", wr_addr2, exp_wr[k] + 32'd4);
        wr_ack = (c == wlat);
        rd_ack = stray && (c < wlat);
        @(negedge clk);
      end
      rd_ack = 1'b0; wr_ack = 1'b0;
    end
    chk("R9 done after last ack", 32'(done), 32'd1);
    chk("R9 busy low with done", 32'(busy), 32'd0);
    chk("R3 no extra request", 32'(rd_req | wr_req), 32'd0);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
    chk("R9 busy stays low", 32'(busy), 32'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    compared++; mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset busy", 32'(busy), 32'd0);
    chk("R12 reset done", 32'(done), 32'd0);
    chk("R12 reset requests", 32'(rd_req | wr_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_job(32'h34, 32'h70, 3, 3, 0, 1, 1, 1, 0, 0, 0, 0);  // R4 R5 frame example
    run_job(32'h34, 32'h70, 3, 3, 1, 1, 1, 1, 2, 1, 1, 0);  // R8 swap, R2 stray acks
    run_job(32'h200, 32'h1000, 4, 2, 0, 0, 1, 1, 1, 0, 0, 0); // R5 narrow step 4
    run_job(32'h50, 32'h300, 2, 3, 0, 0, 0, 0, 0, 2, 0, 0); // R6 hold, R4 no step
    run_job(32'h10, 32'h20, 0, 3, 0, 1, 1, 1, 0, 0, 0, 0);  // R11 zero elements
    run_job(32'h10, 32'h20, 3, 0, 0, 1, 1, 1, 0, 0, 0, 0);  // R11 zero frames
    run_job(32'h80, 32'h600, 3, 1, 0, 1, 1, 1, 1, 0, 0, 1); // R10 start while busy
    run_job(32'hF0, 32'hFF8, 1, 1, 1, 0, 1, 1, 0, 0, 0, 0); // R3 single element
    summary();
  end
endmodule